// File: doc/BRIEF.md
# Logarithmic Number System Arithmetic Unit

This unit does arithmetic on numbers held in logarithmic form. Each word has two parts. The top bit is the sign. The remaining bits hold the base-2 logarithm of the magnitude as a two's-complement fixed-point value. In this form, multiply and divide become a signed add or subtract of the log fields, and square and square root become one-position shifts. Those operations cost no more than an adder.

Adding or subtracting magnitudes is the expensive path. The larger operand becomes the reference x, and its log field is corrected by a value that depends only on the distance d between the two log fields. That correction comes from a small table computed at elaboration and indexed by coarse buckets of d. Past the table's reach the correction is zero.

A 3-bit opcode and a valid strobe launch one operation per cycle. One cycle later the result word appears with its own strobe, plus an overflow flag and an exact-zero flag.

Top module: `lns_alu`

## Requirements
- R1: A 20-bit word has the sign in bit 19 (1 = negative) and the log2 of the magnitude in bits 18:0. That field is two's complement with 8 fractional bits, so its range is -262144 to 262143 LSBs.
- R2: An operation with valid_i high and opcode 0 to 5 gives valid_o high exactly one cycle later. A cycle with valid_i low, or with opcode 6 or 7, gives valid_o low on the next cycle and leaves result_o, ovf_o and zero_o unchanged.
- R3: Opcode 0 (multiply): the log field is la + lb and the sign is the XOR of the operand signs.
- R4: Opcode 1 (divide): the log field is la - lb and the sign is the XOR of the operand signs.
- R5: Opcode 2 (square root): the log field is la shifted right arithmetically by one, rounding toward minus infinity. The sign is 0 and overflow is never raised.
- R6: Opcode 3 (square): the log field is 2·la and the sign is 0.
- R7: Any log value outside -262144..262143 is clamped to the nearest bound and ovf_o is set. Otherwise ovf_o is 0.
- R8: Opcode 4 (magnitude sum): let x be the larger of la and lb, and d = |la - lb|. The log field is x + Cadd(d) and the sign is a's sign. The sign of b has no effect.
- R9: Opcode 5 (magnitude difference): the log field is x + Csub(d). The sign is a's sign when la ≥ lb and its inverse otherwise.
- R10: For d < 2048 LSBs, let k = d >> 5 and t = (k + 0.5)/8. Then Cadd = round(256·log2(1 + 2^-t)) and Csub = round(256·log2(1 - 2^-t)), with rounding half away from zero. For d ≥ 2048 both corrections are 0.
- R11: Opcode 5 with la == lb sets zero_o and gives result word 0 with ovf_o clear. zero_o is 0 after any other operation.
- R12: During reset, result_o, valid_o, ovf_o and zero_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Launches an operation this cycle |
| op_i | input | 3 | Opcode: 0 mul, 1 div, 2 sqrt, 3 square, 4 add, 5 sub |
| a_i | input | 20 | Operand a (sign + log field) |
| b_i | input | 20 | Operand b (sign + log field) |
| result_o | output | 20 | Result word |
| valid_o | output | 1 | Result strobe, one cycle after launch |
| ovf_o | output | 1 | Result log field was clamped |
| zero_o | output | 1 | Magnitude difference of equal operands |

## Verification
The bench builds the unit with its defaults: a 20-bit word, 8 fractional bits, a 64-entry table and a bucket shift of 5. With these values the table covers log distances up to exactly 2048 LSBs. Directed pairs therefore sit on both sides of that edge, on bucket 0, where the difference correction is steepest, and on equal operands. Random full-range operands reach saturation at both bounds through multiply, divide and square. Operand pairs placed close together exercise the sum and difference corrections.

// File: rtl/lns_pkg.sv
package lns_pkg;

  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_DIV  = 3'd1,
    OP_SQRT = 3'd2,
    OP_SQR  = 3'd3,
    OP_ADD  = 3'd4,
    OP_SUB  = 3'd5
  } lns_op_e;

  // correction in log-field LSBs at the centre of bucket k
  function automatic int corr_lsb(int k, int step_sh, int frac_w, bit sub);
    real t, p, v;
    t = (real'(k) + 0.5) * (2.0 ** step_sh) / (2.0 ** frac_w);
    p = 2.0 ** (-t);
    if (sub) v = $ln(1.0 - p) / $ln(2.0);
    else     v = $ln(1.0 + p) / $ln(2.0);
    v = v * (2.0 ** frac_w);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return $rtoi(v - 0.5);
  endfunction

endpackage

// File: rtl/lns_corr_rom.sv
module lns_corr_rom
  import lns_pkg::*;
#(
  parameter int FRAC_W  = 8,
  parameter int IDX_W   = 6,
  parameter int STEP_SH = 5,
  parameter int DIFF_W  = 20,
  parameter int CORR_W  = 16
) (
  input  logic [DIFF_W-1:0]        d_i,
  input  logic                     sub_i,
  output logic signed [CORR_W-1:0] corr_o
);
  localparam int ENTRIES  = 1 << IDX_W;
  localparam int DIFF_LIM = ENTRIES << STEP_SH;

  logic signed [CORR_W-1:0] add_tbl [ENTRIES];
  logic signed [CORR_W-1:0] sub_tbl [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_tbl
    localparam int AV = corr_lsb(k, STEP_SH, FRAC_W, 1'b0);
    localparam int SV = corr_lsb(k, STEP_SH, FRAC_W, 1'b1);
    assign add_tbl[k] = CORR_W'(AV);
    assign sub_tbl[k] = CORR_W'(SV);
  end

  logic [IDX_W-1:0] idx;
  logic             in_rng;

  assign idx    = d_i[STEP_SH +: IDX_W];
  assign in_rng = d_i < DIFF_W'(DIFF_LIM);

  always_comb begin
    if (!in_rng)    corr_o = '0;
    else if (sub_i) corr_o = sub_tbl[idx];
    else            corr_o = add_tbl[idx];
  end

endmodule

// File: rtl/lns_addsub_unit.sv
module lns_addsub_unit #(
  parameter int LOG_W   = 19,
  parameter int FRAC_W  = 8,
  parameter int IDX_W   = 6,
  parameter int STEP_SH = 5,
  parameter int CORR_W  = 16
) (
  input  logic signed [LOG_W-1:0] la_i,
  input  logic signed [LOG_W-1:0] lb_i,
  input  logic                    sub_i,
  output logic signed [LOG_W+1:0] sum_o,
  output logic                    a_ge_o,
  output logic                    eq_o
);
  localparam int EXT_W  = LOG_W + 2;
  localparam int DIFF_W = LOG_W + 1;

  logic signed [LOG_W-1:0]  x, y;
  logic signed [DIFF_W-1:0] diff;
  logic [DIFF_W-1:0]        d_u;
  logic signed [CORR_W-1:0] corr;

  assign a_ge_o = la_i >= lb_i;
  assign eq_o   = la_i == lb_i;
  assign x      = a_ge_o ? la_i : lb_i;
  assign y      = a_ge_o ? lb_i : la_i;
  assign diff   = DIFF_W'(x) - DIFF_W'(y);
  assign d_u    = diff;

  lns_corr_rom #(
    .FRAC_W (FRAC_W),
    .IDX_W  (IDX_W),
    .STEP_SH(STEP_SH),
    .DIFF_W (DIFF_W),
    .CORR_W (CORR_W)
  ) i_rom (
    .d_i   (d_u),
    .sub_i (sub_i),
    .corr_o(corr)
  );

  assign sum_o = EXT_W'(x) + EXT_W'(corr);

endmodule

// File: rtl/lns_mul_unit.sv
module lns_mul_unit
  import lns_pkg::*;
#(
  parameter int LOG_W = 19
) (
  input  logic signed [LOG_W-1:0] la_i,
  input  logic signed [LOG_W-1:0] lb_i,
  input  lns_op_e                 op_i,
  output logic signed [LOG_W+1:0] val_o
);
  localparam int EXT_W = LOG_W + 2;

  logic signed [EXT_W-1:0] a_e, b_e;
  logic signed [LOG_W-1:0] a_half;

  assign a_e    = EXT_W'(la_i);
  assign b_e    = EXT_W'(lb_i);
  assign a_half = la_i >>> 1;

  always_comb begin
    case (op_i)
      OP_MUL:  val_o = a_e + b_e;
      OP_DIV:  val_o = a_e - b_e;
      OP_SQRT: val_o = EXT_W'(a_half);
      OP_SQR:  val_o = a_e <<< 1;
      default: val_o = '0;
    endcase
  end

endmodule

// File: rtl/lns_sat.sv
module lns_sat #(
  parameter int LOG_W = 19
) (
  input  logic signed [LOG_W+1:0] v_i,
  output logic [LOG_W-1:0]        v_o,
  output logic                    ovf_o
);
  localparam int EXT_W = LOG_W + 2;
  localparam logic signed [EXT_W-1:0] MAXV = EXT_W'((64'sd1 <<< (LOG_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] MINV = -MAXV - EXT_W'(1);

  logic hi, lo;

  assign hi    = v_i > MAXV;
  assign lo    = v_i < MINV;
  assign ovf_o = hi | lo;

  always_comb begin
    if (hi)      v_o = MAXV[LOG_W-1:0];
    else if (lo) v_o = MINV[LOG_W-1:0];
    else         v_o = v_i[LOG_W-1:0];
  end

endmodule

// File: rtl/lns_alu.sv
module lns_alu
  import lns_pkg::*;
#(
  parameter int WORD_W  = 20,
  parameter int FRAC_W  = 8,
  parameter int IDX_W   = 6,
  parameter int STEP_SH = 5,
  parameter int CORR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] result_o,
  output logic              valid_o,
  output logic              ovf_o,
  output logic              zero_o
);
  localparam int LOG_W = WORD_W - 1;
  localparam int EXT_W = LOG_W + 2;

  lns_op_e                 op;
  logic                    legal, fire, is_as, sa, sb;
  logic signed [LOG_W-1:0] la, lb;
  logic signed [EXT_W-1:0] mul_val, as_val, wide;
  logic                    a_ge, eq;
  logic [LOG_W-1:0]        sat_val;
  logic                    sat_ovf;
  logic                    sign_n, zero_n, ovf_n;
  logic [WORD_W-1:0]       res_n;

  assign op    = lns_op_e'(op_i);
  assign legal = op_i <= 3'd5;
  assign fire  = valid_i & legal;
  assign is_as = (op == OP_ADD) || (op == OP_SUB);
  assign sa    = a_i[WORD_W-1];
  assign sb    = b_i[WORD_W-1];
  assign la    = a_i[LOG_W-1:0];
  assign lb    = b_i[LOG_W-1:0];

  lns_mul_unit #(.LOG_W(LOG_W)) i_mul (
    .la_i (la),
    .lb_i (lb),
    .op_i (op),
    .val_o(mul_val)
  );

  lns_addsub_unit #(
    .LOG_W  (LOG_W),
    .FRAC_W (FRAC_W),
    .IDX_W  (IDX_W),
    .STEP_SH(STEP_SH),
    .CORR_W (CORR_W)
  ) i_addsub (
    .la_i  (la),
    .lb_i  (lb),
    .sub_i (op == OP_SUB),
    .sum_o (as_val),
    .a_ge_o(a_ge),
    .eq_o  (eq)
  );

  assign wide = is_as ? as_val : mul_val;

  lns_sat #(.LOG_W(LOG_W)) i_sat (
    .v_i  (wide),
    .v_o  (sat_val),
    .ovf_o(sat_ovf)
  );

  always_comb begin
    case (op)
      OP_MUL, OP_DIV: sign_n = sa ^ sb;
      OP_ADD:         sign_n = sa;
      OP_SUB:         sign_n = sa ^ ~a_ge;
      default:        sign_n = 1'b0;
    endcase
  end

  assign zero_n = (op == OP_SUB) && eq;
  assign ovf_n  = sat_ovf & ~zero_n;
  assign res_n  = zero_n ? '0 : {sign_n, sat_val};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      ovf_o    <= 1'b0;
      zero_o   <= 1'b0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        result_o <= res_n;
        ovf_o    <= ovf_n;
        zero_o   <= zero_n;
      end
    end
  end

endmodule

// File: rtl/lns_alu_chk.sv
module lns_alu_chk #(
  parameter int WORD_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic [WORD_W-1:0] result_o,
  input logic              valid_o,
  input logic              ovf_o,
  input logic              zero_o
);
  localparam int LOG_W = WORD_W - 1;
  localparam logic [LOG_W-1:0] LMAX = {1'b0, {(LOG_W-1){1'b1}}};
  localparam logic [LOG_W-1:0] LMIN = {1'b1, {(LOG_W-1){1'b0}}};

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd5) |=> valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i <= 3'd5) |=> !valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i <= 3'd5) |=> ($stable(result_o) && $stable(ovf_o) && $stable(zero_o))); // R2
  AST_MUL_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0) |=> result_o[WORD_W-1] == $past(a_i[WORD_W-1] ^ b_i[WORD_W-1])); // R3
  AST_ROOT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2) |=> (!ovf_o && !result_o[WORD_W-1])); // R5
  AST_OVF_AT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (result_o[LOG_W-1:0] == LMAX || result_o[LOG_W-1:0] == LMIN)); // R7
  AST_ZERO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (result_o == '0 && !ovf_o)); // R11
  AST_ZERO_ONLY_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd4) |=> !zero_o); // R11

endmodule

bind lns_alu lns_alu_chk #(.WORD_W(WORD_W)) i_lns_alu_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .result_o(result_o),
  .valid_o (valid_o),
  .ovf_o   (ovf_o),
  .zero_o  (zero_o)
);

// File: tb/test_lns_alu.sv
`timescale 1ns/1ps
module test_lns_alu;
  localparam int W  = 20;
  localparam int LW = 19;
  localparam int LMAX = (1 << (LW - 1)) - 1;
  localparam int LMIN = -(1 << (LW - 1));

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] result_o;
  logic         valid_o, ovf_o, zero_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] e_res = '0;
  logic         e_valid = 0, e_ovf = 0, e_zero = 0;
  string        e_req = "R12";

  always #2.5 clk_i = ~clk_i;

  lns_alu i_lns_alu (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i,
    .result_o, .valid_o, .ovf_o, .zero_o
  );

  function automatic logic [W-1:0] mk(bit s, int l);
    logic [W-1:0] w;
    w = {s, l[LW-1:0]};
    return w;
  endfunction

  function automatic int lg(logic [W-1:0] w);
    int v;
    v = int'(w[LW-1:0]);
    if (w[LW-1]) v = v - (1 << LW);
    return v;
  endfunction

  // R10 correction model
  function automatic int corr(int d, bit sub);
    real t, v;
    if (d >= 2048) return 0;
    t = (real'(d / 32) + 0.5) / 8.0;
    if (sub) v = $log10(1.0 - 2.0 ** (-t)) / $log10(2.0);
    else     v = $log10(1.0 + 2.0 ** (-t)) / $log10(2.0);
    return int'(256.0 * v);
  endfunction

  task automatic model(bit v, int op, logic [W-1:0] a, logic [W-1:0] b);
    int la, lb, x, d, r;
    bit s;
    if (!(v && op <= 5)) begin
      e_valid = 0;
      e_req = "R2";
      return;
    end
    la = lg(a); lb = lg(b);
    x = (la >= lb) ? la : lb;
    d = (la >= lb) ? la - lb : lb - la;
    s = 0;
    case (op)
      0: begin r = la + lb; s = a[W-1] ^ b[W-1]; e_req = "R1 R3"; end
      1: begin r = la - lb; s = a[W-1] ^ b[W-1]; e_req = "R4"; end
      2: begin r = (la < 0 && (la % 2) != 0) ? la / 2 - 1 : la / 2; e_req = "R5"; end
      3: begin r = 2 * la; e_req = "R6"; end
      4: begin r = x + corr(d, 0); s = a[W-1]; e_req = "R8 R10"; end
      default: begin r = x + corr(d, 1); s = (la >= lb) ? a[W-1] : ~a[W-1]; e_req = "R9 R10"; end
    endcase
    e_valid = 1;
    e_zero = 0;
    e_ovf = 0;
    if (op == 5 && la == lb) begin
      e_zero = 1;
      e_res = '0;
      e_req = "R11";
      return;
    end
    if (r > LMAX) begin r = LMAX; e_ovf = 1; e_req = "R7"; end
    if (r < LMIN) begin r = LMIN; e_ovf = 1; e_req = "R7"; end
    e_res = mk(s, r);
  endtask

  task automatic check();
    n_checks++;
    if (result_o !== e_res || valid_o !== e_valid || ovf_o !== e_ovf || zero_o !== e_zero) begin
      n_fail++;
      $display("FAIL %s: res=%h/%h valid=%b/%b ovf=%b/%b zero=%b/%b (actual/expected)",
               e_req, result_o, e_res, valid_o, e_valid, ovf_o, e_ovf, zero_o, e_zero);
    end
  endtask

  task automatic drive(bit v, int op, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk_i);
    check();
    model(v, op, a, b);
    valid_i = v; op_i = op[2:0]; a_i = a; b_i = b;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int la, lb;
    // R12 reset state
    repeat (2) @(negedge clk_i);
    check();
    rst_ni = 1'b1;
    // R3 8*4 -> 32
    drive(1, 0, mk(0, 768), mk(1, 512));
    // R4 divide
    drive(1, 1, mk(1, 768), mk(1, -512));
    // R5 odd negative root floors
    drive(1, 2, mk(1, -3), mk(0, 0));
    drive(1, 2, mk(0, 1025), mk(0, 0));
    // R6 square, and R7 saturation both ways
    drive(1, 3, mk(0, -700), mk(0, 0));
    drive(1, 3, mk(0, 200000), mk(0, 0));
    drive(1, 0, mk(0, -200000), mk(0, -100000));
    drive(1, 1, mk(0, 200000), mk(0, -100000));
    // R8 sum, b sign ignored
    drive(1, 4, mk(0, 1000), mk(1, 1000));
    drive(1, 4, mk(1, 1000), mk(0, 990));
    // R10 table edge
    drive(1, 4, mk(0, 5000), mk(0, 5000 - 2047));
    drive(1, 4, mk(0, 5000), mk(0, 5000 - 2048));
    drive(1, 5, mk(0, 5000), mk(0, 5000 - 2047));
    drive(1, 5, mk(0, 5000), mk(0, 5000 - 2048));
    // R9 difference, b larger flips sign; bucket 0
    drive(1, 5, mk(0, 300), mk(0, 301));
    drive(1, 5, mk(1, 262000), mk(0, 261999));
    // R11 equal magnitudes
    drive(1, 5, mk(1, 4321), mk(0, 4321));
    // R2 illegal opcode and idle hold
    drive(1, 6, mk(0, 1), mk(0, 2));
    drive(1, 7, mk(0, 1), mk(0, 2));
    drive(0, 0, mk(0, 9), mk(0, 9));
    drive(1, 4, mk(0, LMAX), mk(0, LMAX));
    // random mix
    for (int i = 0; i < 4000; i++) begin
      la = int'($urandom_range(0, (1 << LW) - 1)) + LMIN;
      if ($urandom_range(0, 1) == 1) lb = la + int'($urandom_range(0, 2600)) - 1300;
      else lb = int'($urandom_range(0, (1 << LW) - 1)) + LMIN;
      if (lb > LMAX) lb = LMAX;
      if (lb < LMIN) lb = LMIN;
      if ($urandom_range(0, 15) == 0) lb = la;
      drive($urandom_range(0, 3) != 0, int'($urandom_range(0, 7)),
            mk(1'($urandom_range(0, 1)), la), mk(1'($urandom_range(0, 1)), lb));
    end
    drive(0, 0, '0, '0);
    @(negedge clk_i);
    check();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule